// File: doc/BRIEF.md
# Register-List Multiple Load/Store Sequencer

This block carries out a load-multiple or store-multiple operation described by a compact five-bit register-list field. On a start pulse it captures a base address, the list field, a direction select (load or store) and a size select (32-bit word or 64-bit doubleword). It then steps through a fixed, non-contiguous register map. Each step is one memory access, and the address advances by the access size after every transfer.

For a store, the sequencer presents a register number on the register-file read port and forwards the read data to memory. For a load, it writes the memory response into the register file on the cycle the response arrives. Word loads are sign-extended to the register width. Only one memory request is outstanding at any time, and a single-cycle done pulse marks the end of the operation.

Top module: `reglist_xfer_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, busy_o, done_o, mem_req_o and rf_we_o are all low.
- R2: A count field list_i[3:0] between 1 and 9 transfers that many registers, taken in the order 16, 17, 18, 19, 20, 21, 22, 23, 30.
- R3: A count field of 0, or of 10 to 15, transfers no registers from the base map.
- R4: When list_i[4] is 1, register 31 is transferred once, after every base-map register, at the next sequential address.
- R5: Transfer k (counting from 0) uses mem_addr_o = base + 4*k when dword_i=0, and base + 8*k when dword_i=1. mem_dword_o shows the size that was captured.
- R6: A store (is_load_i=0) drives mem_we_o=1, and mem_wdata_o equals rf_rdata_i for the register shown on rf_raddr_o. A word store uses bits [31:0].
- R7: A load (is_load_i=1) drives mem_we_o=0 and raises rf_we_o on the acknowledge cycle. The load writes mem_rdata_i to rf_waddr_o unchanged for doublewords. For words it writes mem_rdata_i[31:0] sign-extended from bit 31.
- R8: mem_req_o stays high with a stable address and direction until mem_ack_i is sampled high. Each acknowledge completes exactly one transfer.
- R9: done_o is high for exactly one cycle. It rises in the cycle after the final acknowledge, or in the cycle after start when no transfers are requested.
- R10: A start_i pulse while busy_o is high is ignored. The running operation completes unchanged, and no further transfers follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| is_load_i | input | 1 | 1 = load multiple, 0 = store multiple |
| dword_i | input | 1 | 1 = 8-byte accesses, 0 = 4-byte accesses |
| list_i | input | 5 | [3:0] base count, [4] append register 31 |
| base_addr_i | input | ADDR_W | Address of the first transfer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | 5 | Register-file read index (stores) |
| rf_rdata_i | input | XLEN | Register-file read data, combinational |
| rf_we_o | output | 1 | Register-file write enable (loads) |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write request |
| mem_dword_o | output | 1 | Access size, 1 = 8 bytes |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | XLEN | Store data |
| mem_ack_i | input | 1 | Request accepted and completed this cycle |
| mem_rdata_i | input | XLEN | Load data, valid with mem_ack_i |

## Verification
The checks assume that the memory side raises mem_ack_i only while mem_req_o is high, and that it returns load data in the same cycle as the acknowledge. They also assume that the register file answers reads combinationally. The bench memory model acknowledges a request only while it is pending, and it varies the wait from zero to two cycles. The load data it returns is a fixed function of the address. The register-file model is an array read without delay, and inputs change only on the falling edge. The sweep covers all 32 list values in both directions and both sizes. One run fires a second start in the middle of an operation.

// File: rtl/reglist_xfer_pkg.sv
package reglist_xfer_pkg;
  localparam int unsigned REG_IDX_W = 5;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic is_load;
    logic dword;
  } op_mode_t;
endpackage

// File: rtl/reglist_decode.sv
module reglist_decode #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned MAP_LEN = 9,
  parameter int unsigned STEP_W  = 4
) (
  input  logic [CNT_W:0]    list_i,
  output logic [STEP_W-1:0] n_base_o,
  output logic [STEP_W-1:0] total_o
);
  logic [CNT_W-1:0] cnt;
  logic             in_range;

  always_comb begin
    cnt      = list_i[CNT_W-1:0];
    in_range = (cnt != '0) && (32'(cnt) <= MAP_LEN);
    n_base_o = in_range ? STEP_W'(cnt) : '0;
    total_o  = n_base_o + STEP_W'(list_i[CNT_W]);
  end
endmodule

// File: rtl/reglist_regmap.sv
module reglist_regmap #(
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned MAP_LEN   = 9,
  parameter int unsigned FIRST_REG = 16,
  parameter int unsigned TAIL_REG  = 30,
  parameter int unsigned LINK_REG  = 31
) (
  input  logic [STEP_W-1:0]                         step_i,
  input  logic [STEP_W-1:0]                         n_base_i,
  output logic [reglist_xfer_pkg::REG_IDX_W-1:0]    reg_o
);
  import reglist_xfer_pkg::*;

  logic [REG_IDX_W-1:0] map_tbl [MAP_LEN];
  logic [REG_IDX_W-1:0] pick;

  for (genvar g = 0; g < MAP_LEN; g++) begin : g_map
    if (g == MAP_LEN - 1) begin : g_tail
      assign map_tbl[g] = REG_IDX_W'(TAIL_REG);
    end else begin : g_run
      assign map_tbl[g] = REG_IDX_W'(FIRST_REG + g);
    end
  end

  always_comb begin
    pick = REG_IDX_W'(LINK_REG);
    for (int i = 0; i < MAP_LEN; i++) begin
      if (32'(step_i) == i) pick = map_tbl[i];
    end
    reg_o = (step_i < n_base_i) ? pick : REG_IDX_W'(LINK_REG);
  end
endmodule

// File: rtl/reglist_ldfmt.sv
module reglist_ldfmt #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic            dword_i,
  input  logic [XLEN-1:0] raw_i,
  output logic [XLEN-1:0] ext_o
);
  localparam int unsigned PAD_W = XLEN - WORD_W;

  always_comb begin
    if (dword_i) ext_o = raw_i;
    else         ext_o = {{PAD_W{raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
  end
endmodule

// File: rtl/reglist_xfer_seq.sv
module reglist_xfer_seq #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned XLEN      = 64,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned MAP_LEN   = 9,
  parameter int unsigned FIRST_REG = 16,
  parameter int unsigned TAIL_REG  = 30,
  parameter int unsigned LINK_REG  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_load_i,
  input  logic              dword_i,
  input  logic [CNT_W:0]    list_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [4:0]        rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_dword_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [XLEN-1:0]   mem_rdata_i
);
  import reglist_xfer_pkg::*;

  localparam int unsigned STEP_W   = $clog2(MAP_LEN + 2);
  localparam int unsigned WORD_B   = WORD_W / 8;
  localparam int unsigned DWORD_B  = XLEN / 8;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // state
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [STEP_W-1:0] total_q, nbase_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  op_mode_t          mode_q;
  logic              done_q, done_d;

  logic [STEP_W-1:0] dec_nbase, dec_total;
  logic [4:0]        cur_reg;
  logic [XLEN-1:0]   load_ext;
  logic [ADDR_W-1:0] stride;

  logic accept, xfer, last_xfer, run, cap_en, adv_en;

  reglist_decode #(
    .CNT_W  (CNT_W),
    .MAP_LEN(MAP_LEN),
    .STEP_W (STEP_W)
  ) u_decode (
    .list_i  (list_i),
    .n_base_o(dec_nbase),
    .total_o (dec_total)
  );

  reglist_regmap #(
    .STEP_W   (STEP_W),
    .MAP_LEN  (MAP_LEN),
    .FIRST_REG(FIRST_REG),
    .TAIL_REG (TAIL_REG),
    .LINK_REG (LINK_REG)
  ) u_regmap (
    .step_i  (step_q),
    .n_base_i(nbase_q),
    .reg_o   (cur_reg)
  );

  reglist_ldfmt #(
    .XLEN  (XLEN),
    .WORD_W(WORD_W)
  ) u_ldfmt (
    .dword_i(mode_q.dword),
    .raw_i  (mem_rdata_i),
    .ext_o  (load_ext)
  );

  // next-state logic
  always_comb begin
    run       = (state_q == SEQ_RUN);
    accept    = (state_q == SEQ_IDLE) && start_i;
    xfer      = run && mem_ack_i;
    last_xfer = xfer && (step_q == total_q - 1'b1);
    cap_en    = accept;
    adv_en    = xfer;
    stride    = mode_q.dword ? ADDR_W'(DWORD_B) : ADDR_W'(WORD_B);

    state_d = state_q;
    if (accept && (dec_total != '0)) state_d = SEQ_RUN;
    else if (last_xfer)              state_d = SEQ_IDLE;

    step_d = step_q;
    addr_d = addr_q;
    if (cap_en) begin
      step_d = '0;
      addr_d = base_addr_i;
    end else if (adv_en) begin
      step_d = step_q + 1'b1;
      addr_d = addr_q + stride;
    end

    done_d = (accept && (dec_total == '0)) || last_xfer;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      step_q <= '0;
      addr_q <= '0;
    end else if (cap_en || adv_en) begin
      step_q <= step_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      total_q <= '0;
      nbase_q <= '0;
      mode_q  <= '0;
    end else if (cap_en) begin
      total_q <= dec_total;
      nbase_q <= dec_nbase;
      mode_q  <= '{is_load: is_load_i, dword: dword_i};
    end
  end

  // outputs
  assign busy_o      = run;
  assign done_o      = done_q;
  assign mem_req_o   = run;
  assign mem_we_o    = run && !mode_q.is_load;
  assign mem_dword_o = mode_q.dword;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_raddr_o  = cur_reg;
  assign rf_we_o     = xfer && mode_q.is_load;
  assign rf_waddr_o  = cur_reg;
  assign rf_wdata_o  = load_ext;
endmodule

// File: rtl/reglist_xfer_seq_chk.sv
module reglist_xfer_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_dword_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              rf_we_o,
  input logic [4:0]        rf_raddr_o
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !done_o && !mem_req_o && !rf_we_o));

  p_reg_in_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ((rf_raddr_o >= 5'd16 && rf_raddr_o <= 5'd23) ||
                   rf_raddr_o == 5'd30 || rf_raddr_o == 5'd31));

  p_link_is_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i && rf_raddr_o == 5'd31) |=> !mem_req_o);

  p_addr_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_ack_i) |=>
      (!mem_req_o ||
       mem_addr_o == $past(mem_addr_o) + ($past(mem_dword_o) ? ADDR_W'(8) : ADDR_W'(4))));

  p_write_only_on_load_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_ack_i && !mem_we_o));

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(busy_o)) |-> $past(mem_ack_i));
endmodule

bind reglist_xfer_seq reglist_xfer_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_dword_o(mem_dword_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .rf_we_o    (rf_we_o),
  .rf_raddr_o (rf_raddr_o)
);

// File: tb/reglist_xfer_seq_tb.sv
module reglist_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, is_load_i, dword_i;
  logic [4:0]  list_i;
  logic [31:0] base_addr_i;
  logic        busy_o, done_o, rf_we_o, mem_req_o, mem_we_o, mem_dword_o;
  logic [4:0]  rf_raddr_o, rf_waddr_o;
  logic [63:0] rf_rdata_i, rf_wdata_o, mem_wdata_o, mem_rdata_i;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i;

  logic [63:0] rf_model [32];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lat    = 0;
  int wc     = 0;

  // transfer log
  int          n_log;
  int          last_ack_cyc;
  int          hold_err;
  logic [31:0] log_addr [16];
  logic [4:0]  log_reg  [16];
  logic [63:0] log_data [16];
  logic        log_we   [16];
  logic        prev_req, prev_ack;
  logic [31:0] prev_addr;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, a * 32'h9E37_79B1};
  endfunction

  assign mem_rdata_i = pat(mem_addr_o);
  assign rf_rdata_i  = rf_model[rf_raddr_o];

  reglist_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_load_i(is_load_i),
    .dword_i(dword_i), .list_i(list_i), .base_addr_i(base_addr_i),
    .busy_o(busy_o), .done_o(done_o), .rf_raddr_o(rf_raddr_o),
    .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_dword_o(mem_dword_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  // memory model: acknowledges after lat wait cycles (R8)
  always @(negedge clk) begin
    if (mem_ack_i) wc = 0;
    if (mem_req_o && wc >= lat) mem_ack_i = 1'b1;
    else begin
      mem_ack_i = 1'b0;
      if (mem_req_o) wc = wc + 1;
      else wc = 0;
    end
  end

  // monitor, sampled just after the falling edge
  always @(negedge clk) begin
    #1;
    if (prev_req && !prev_ack && (!mem_req_o || mem_addr_o != prev_addr))
      hold_err = hold_err + 1;
    if (mem_req_o && mem_ack_i && n_log < 16) begin
      log_addr[n_log] = mem_addr_o;
      log_we[n_log]   = mem_we_o;
      if (mem_we_o) begin
        log_reg[n_log]  = rf_raddr_o;
        log_data[n_log] = mem_wdata_o;
      end else begin
        log_reg[n_log]  = rf_we_o ? rf_waddr_o : 5'd0;
        log_data[n_log] = rf_wdata_o;
        if (rf_we_o) rf_model[rf_waddr_o] = rf_wdata_o;
      end
      n_log        = n_log + 1;
      last_ack_cyc = cyc;
    end
    prev_req  = mem_req_o;
    prev_ack  = mem_ack_i;
    prev_addr = mem_addr_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] lst, input logic ld, input logic dw,
                        input logic [31:0] base, input bit poke_busy);
    int n_base, total, start_cyc, done_cyc, guard;
    logic [63:0] snap [32];
    logic [4:0]  er;
    logic [31:0] ea;
    logic [63:0] ed;
    for (int r = 0; r < 32; r++) snap[r] = rf_model[r];
    n_base = (lst[3:0] >= 1 && lst[3:0] <= 9) ? int'(lst[3:0]) : 0;
    total  = n_base + int'(lst[4]);
    @(negedge clk);
    n_log = 0; hold_err = 0;
    start_i = 1'b1; is_load_i = ld; dword_i = dw; list_i = lst; base_addr_i = base;
    start_cyc = cyc;
    guard = 0; done_cyc = -1;
    while (done_cyc < 0 && guard < 200) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke_busy && guard == 1) begin
        // R10: second start mid-operation with different operands
        start_i = 1'b1; is_load_i = ~ld; dword_i = ~dw; list_i = 5'h1F;
        base_addr_i = 32'hDEAD_0000;
      end
      #2;
      if (done_o) done_cyc = cyc;
      guard++;
    end
    start_i = 1'b0;
    chk(done_cyc >= 0, "R9", "done seen", 64'(done_cyc), 64'(0));
    chk(n_log == total, (total == n_base + 1) ? "R4" : (n_base == 0 ? "R3" : "R2"),
        "transfer count", 64'(n_log), 64'(total));
    for (int k = 0; k < total && k < n_log; k++) begin
      er = (k < n_base) ? ((k < 8) ? 5'(16 + k) : 5'd30) : 5'd31;
      ea = base + 32'(k) * (dw ? 32'd8 : 32'd4);
      if (ld) ed = dw ? pat(ea) : {{32{pat(ea)[31]}}, pat(ea)[31:0]};
      else    ed = snap[er];
      chk(log_reg[k] == er, (er == 5'd31) ? "R4" : "R2", "register",
          64'(log_reg[k]), 64'(er));
      chk(log_addr[k] == ea, "R5", "address", 64'(log_addr[k]), 64'(ea));
      chk(log_we[k] == !ld, ld ? "R7" : "R6", "direction",
          64'(log_we[k]), 64'(!ld));
      chk(log_data[k] == ed, ld ? "R7" : "R6", "data", log_data[k], ed);
    end
    if (total == 0)
      chk(done_cyc == start_cyc + 1, "R9", "done cycle (empty)",
          64'(done_cyc), 64'(start_cyc + 1));
    else
      chk(done_cyc == last_ack_cyc + 1, "R9", "done cycle",
          64'(done_cyc), 64'(last_ack_cyc + 1));
    chk(hold_err == 0, "R8", "request held until ack", 64'(hold_err), 64'(0));
    @(negedge clk); #2;
    chk(done_o == 1'b0, "R9", "done single pulse", 64'(done_o), 64'(0));
    if (poke_busy) begin
      repeat (3) begin @(negedge clk); #2; end
      chk(!busy_o && !mem_req_o && n_log == total, "R10",
          "no extra transfers after ignored start", 64'(n_log), 64'(total));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; is_load_i = 1'b0; dword_i = 1'b0;
    list_i = '0; base_addr_i = '0; mem_ack_i = 1'b0;
    prev_req = 1'b0; prev_ack = 1'b0; prev_addr = '0;
    n_log = 0; last_ack_cyc = 0; hold_err = 0;
    for (int r = 0; r < 32; r++)
      rf_model[r] = 64'hF0E1_D2C3_0000_0000 ^ (64'(r) * 64'h0101_0101_8421_0421);
    repeat (3) @(negedge clk);
    #2;
    // R1: outputs idle during reset
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R1", "idle in reset",
        {60'd0, busy_o, done_o, mem_req_o, rf_we_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R1", "idle after reset",
        {60'd0, busy_o, done_o, mem_req_o, rf_we_o}, 64'd0);
    repeat (3) @(negedge clk);

    // exhaustive sweep: every list value, both directions, both sizes,
    // memory wait varied 0..2 cycles (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int op = 0; op < 128; op++) begin
      lat = op % 3;
      run_op(5'(op), op[5], op[6], 32'h1000_0000 + 32'(op) * 32'h40, 1'b0);
    end

    // R10: start pulse while busy is ignored
    lat = 2;
    run_op(5'h15, 1'b0, 1'b1, 32'h2000_0100, 1'b1);
    lat = 1;
    run_op(5'h09, 1'b1, 1'b0, 32'h3000_0000, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule